// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt lines from board peripherals into a single registered interrupt toward the processor. The lines are assigned as follows:

- 0: storage card
- 1: smart card
- 2: USB client
- 3: Ethernet
- 4: audio codec
- 5: pen
- 6: module insertion
- 7: expansion board
- 9, 10, 11: detect, status change and interrupt of card socket 0
- 13, 14, 15: detect, status change and interrupt of card socket 1

Lines 8 and 12 are reserved.

Software reaches three interrupt registers through a word-wide port that decodes a 1 MiB offset window.

- The enable register decides which lines may latch.
- The pending register holds sticky flags. Software clears them by writing zeros.
- The raw-level register mirrors the live level of every line.

Both control registers drop bit positions 8 and 12 on every write. Bits 16 to 19 are kept and serve as software-only interrupt sources.

The same window also holds four plain storage words for neighbouring board functions (LED data, LED control and two card-socket registers). This block only stores those words and reads them back.

Top module: `irq_agg`

## Requirements
- R1: After reset `irq_out` is 0, and the enable (offset 0xC0), pending (0xD0) and raw-level (0xC8) registers all read 0.
- R2: The raw-level register at 0xC8 reads, in bits 15:0, the levels that `irq_lines` had at the previous clock edge, whatever the enable bits are. Writes to 0xC8 have no effect.
- R3: A pending bit is set at a clock edge only when its line is high and its enable bit is already set. A high line whose enable bit is clear leaves its pending bit at 0.
- R4: A pending bit stays set after its line returns low, until software writes a 0 to it.
- R5: `irq_out` equals the OR over bits 19:0 of (pending AND enable). It changes at the clock edge on which the causing line level or register write is sampled, not before that edge.
- R6: A write to 0xC0 stores `reg_wdata & 0xFEEFF` (bits 8, 12 and 20-31 forced to 0). The value reads back, and the next edge recomputes `irq_out` with it.
- R7: A write to 0xD0 stores `reg_wdata & 0xFEEFF`. Writing zeros clears pending bits, and a software-set bit that is enabled asserts `irq_out`.
- R8: The storage words at offsets 0x10, 0x14, 0x40 and 0xE4 hold and read back all 32 bits. Reads of unmapped offsets return 0.
- R9: When a pending write and a latching line meet on the same edge, the line wins: the enabled, high line's pending bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Level interrupt lines from peripherals |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 20 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Registered level interrupt to the processor |

## Verification
The hardest situation to reach from the ports is a clearing write to the pending register on the very edge at which an enabled line is high. It arises only when an enable has been set, the line is being held, and the write lands during that hold. The bench keeps the line asserted across a zero write to 0xD0 and then reads the pending bit back.

Reserved positions are a second corner. Driving lines 8 and 12 high while every writable enable bit is set must leave both the pending register and `irq_out` quiet.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int N_LINES = 16,
  parameter int AW      = 20,
  parameter int DW      = 32,
  parameter int RW      = 20,
  parameter logic [RW-1:0] WR_MASK  = 20'hFEEFF,
  parameter logic [AW-1:0] OFF_EN   = 20'h000C0,
  parameter logic [AW-1:0] OFF_RAW  = 20'h000C8,
  parameter logic [AW-1:0] OFF_PEND = 20'h000D0,
  parameter int N_AUX   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq_out
);

  function automatic logic [AW-1:0] aux_off(input int i);
    case (i)
      0:       return AW'(32'h10);
      1:       return AW'(32'h14);
      2:       return AW'(32'h40);
      default: return AW'(32'hE4);
    endcase
  endfunction

  logic [RW-1:0]      en_q, pend_q;
  logic [N_LINES-1:0] raw_q;
  logic               irq_q;
  logic [DW-1:0]      aux_q [N_AUX];

  wire [RW-1:0] lines_w = RW'(irq_lines);
  wire          wr_en   = reg_wr && (reg_addr == OFF_EN);
  wire          wr_pend = reg_wr && (reg_addr == OFF_PEND);
  wire [RW-1:0] wval    = reg_wdata[RW-1:0] & WR_MASK;

  wire [RW-1:0] en_d   = wr_en ? wval : en_q;
  wire [RW-1:0] pend_d = (wr_pend ? wval : pend_q) | (lines_w & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      raw_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      raw_q  <= irq_lines;
      irq_q  <= |(pend_d & en_d);
    end
  end

  for (genvar g = 0; g < N_AUX; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rst_n)
        aux_q[g] <= '0;
      else if (reg_wr && reg_addr == aux_off(g))
        aux_q[g] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_EN)   reg_rdata = DW'(en_q);
    if (reg_addr == OFF_PEND) reg_rdata = DW'(pend_q);
    if (reg_addr == OFF_RAW)  reg_rdata = DW'(raw_q);
    for (int i = 0; i < N_AUX; i++)
      if (reg_addr == aux_off(i)) reg_rdata = aux_q[i];
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_LINES = 16,
  parameter int AW      = 20,
  parameter int DW      = 32,
  parameter int RW      = 20,
  parameter logic [RW-1:0] WR_MASK  = 20'hFEEFF,
  parameter logic [AW-1:0] OFF_PEND = 20'h000D0,
  parameter logic [AW-1:0] OFF_EN   = 20'h000C0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] irq_lines,
  input logic               reg_wr,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic [RW-1:0]      en_q,
  input logic [RW-1:0]      pend_q,
  input logic [N_LINES-1:0] raw_q,
  input logic               irq_out
);
  wire          c_wr_pend = reg_wr && (reg_addr == OFF_PEND);
  wire          c_wr_en   = reg_wr && (reg_addr == OFF_EN);
  wire [RW-1:0] c_live    = RW'(irq_lines) & en_q;

  assert_raw_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q == $past(irq_lines));

  assert_pend_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !c_wr_pend |=> ((pend_q & ~$past(pend_q)) & ~$past(c_live)) == '0);

  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !c_wr_pend |=> (pend_q & $past(pend_q)) == $past(pend_q));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == |(pend_q & en_q));

  assert_en_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |=> en_q == ($past(reg_wdata[RW-1:0]) & WR_MASK));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_pend |=> (pend_q & $past(c_live)) == $past(c_live));
endmodule

bind irq_agg irq_agg_chk #(
  .N_LINES(N_LINES), .AW(AW), .DW(DW), .RW(RW),
  .WR_MASK(WR_MASK), .OFF_PEND(OFF_PEND), .OFF_EN(OFF_EN)
) u_chk (.*);

// File: tb/irq_agg_tb.sv
`timescale 1ns/100ps
module irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic        reg_wr = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [19:0] A_EN = 20'hC0, A_RAW = 20'hC8, A_PEND = 20'hD0;

  always #2.5 clk = ~clk;

  irq_agg u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk); irq_lines = v; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq_out), 0);
    rd(A_EN, d);   check("R1 en", d, 0);
    rd(A_PEND, d); check("R1 pend", d, 0);
    rd(A_RAW, d);  check("R1 raw", d, 0);
  endtask

  task automatic t_raw_unlatched;
    logic [31:0] d;
    set_lines(16'hA5A5);
    rd(A_RAW, d);  check("R2 raw mirror", d, 32'hA5A5);
    rd(A_PEND, d); check("R3 masked no latch", d, 0);
    check("R3 irq stays low", 32'(irq_out), 0);
    set_lines(16'h0000);
    rd(A_RAW, d);  check("R2 raw follows low", d, 0);
  endtask

  task automatic t_latch_sticky;
    logic [31:0] d;
    wr(A_EN, 32'h8);
    @(negedge clk); irq_lines = 16'h0008; #0.5;
    check("R5 no early irq", 32'(irq_out), 0);
    @(negedge clk);
    check("R5 irq after edge", 32'(irq_out), 1);
    rd(A_PEND, d); check("R3 latch", d, 32'h8);
    set_lines(16'h0000);
    rd(A_PEND, d); check("R4 sticky", d, 32'h8);
    check("R4 irq held", 32'(irq_out), 1);
  endtask

  task automatic t_enable_write;
    logic [31:0] d;
    wr(A_EN, 32'h0);
    check("R6 irq drops on mask", 32'(irq_out), 0);
    rd(A_PEND, d); check("R6 pend kept", d, 32'h8);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R6 reserved dropped", d, 32'hFEEFF);
    check("R6 irq recomputed", 32'(irq_out), 1);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R7 clear by zero", d, 0);
    check("R7 irq cleared", 32'(irq_out), 0);
  endtask

  task automatic t_soft_set;
    logic [31:0] d;
    wr(A_PEND, 32'hFFFF_1100);
    rd(A_PEND, d); check("R7 masked store", d, 32'hF0000);
    check("R7 soft irq", 32'(irq_out), 1);
    wr(A_PEND, 32'h0);
    check("R7 soft clear", 32'(irq_out), 0);
  endtask

  task automatic t_reserved_lines;
    logic [31:0] d;
    set_lines(16'h1100);
    rd(A_PEND, d); check("R6 reserved lines no pend", d, 0);
    check("R6 reserved lines no irq", 32'(irq_out), 0);
    set_lines(16'h0000);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(A_EN, 32'h20);
    @(negedge clk); irq_lines = 16'h0020;
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R9 line beats clear", d, 32'h20);
    check("R9 irq", 32'(irq_out), 1);
    set_lines(16'h0000);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R9 clear after drop", d, 0);
  endtask

  task automatic t_storage;
    logic [31:0] d;
    wr(20'hE4, 32'hDEADBEEF);
    wr(20'h10, 32'h1234_5678);
    rd(20'hE4, d); check("R8 store E4", d, 32'hDEADBEEF);
    rd(20'h10, d); check("R8 store 10", d, 32'h1234_5678);
    rd(20'h44, d); check("R8 unmapped zero", d, 0);
    set_lines(16'h0041);
    wr(A_RAW, 32'h0);
    rd(A_RAW, d); check("R2 raw write ignored", d, 32'h41);
    set_lines(16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_unlatched();
    t_latch_sticky();
    t_enable_write();
    t_soft_set();
    t_reserved_lines();
    t_set_wins();
    t_storage();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule